// File: doc/BRIEF.md
# DSP Y-Bus Accumulator Load Unit

This unit handles the Y-bus portion of a 32-bit DSP instruction word. Each valid instruction moves at most one value: a word from one of four data RAM banks into the operand register RY, a word from a RAM bank into the 48-bit accumulator, the ALU result into the accumulator, or zero into the accumulator. The accumulator is held as a 16-bit high part and a 32-bit low part.

Each RAM bank has its own 6-bit read-address counter, which the unit owns. RAM-source transfers read the chosen bank at its current counter value. They may also step that counter by one after the transfer. The counter values and a per-bank increment strobe are outputs, so the surrounding datapath can drive the RAM read addresses and follow the stepping. The RAM arrays, the ALU and the other instruction fields are outside this unit.

Top module: `ybus_acc_load`

## Requirements
- R1: The unit changes no register or counter and raises no strobe in two cases: `instr_vld` is low, or instruction bits 31:30 are not 00.
- R2: Field codes 000, 101, 110 and 111 in bits 19:17 change no register and no counter and raise no strobe. This holds even when bit 16 is set.
- R3: Code 001 sets `acc_hi` and `acc_lo` to zero.
- R4: Code 010 loads bits 47:32 of `alu_res` into `acc_hi` and bits 31:0 into `acc_lo`.
- R5: Code 011 loads the word of the bank chosen by bits 15:14 into `acc_lo`, where bank number = value of bits 15:14. It fills `acc_hi` with 16 copies of bit 31 of that word. The word is the one present on `ram_rdata` for that bank, read at that bank's current counter address.
- R6: Code 100 loads the chosen bank's word into `ry_q` and leaves `acc_hi` and `acc_lo` unchanged.
- R7: For codes 011 and 100 with bit 16 set, only the chosen bank's counter increments by one. Its `ctr_inc` bit is high in the cycle the instruction is presented. With bit 16 clear, no counter changes and no strobe is raised.
- R8: A counter at 63 goes to 0 when incremented.
- R9: While `rst_n` is low at a rising edge, `ry_q`, `acc_hi`, `acc_lo` and all counters become zero.
- R10: Register and counter results appear after the first rising edge at which the instruction is presented. `ctr_inc` is combinational in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_vld | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | DSP instruction word |
| ram_rdata | input | 4x32 | Read data of banks 0..3 at their counter addresses |
| alu_res | input | 48 | ALU result |
| ry_q | output | 32 | Operand register RY |
| acc_hi | output | 16 | Accumulator high part |
| acc_lo | output | 32 | Accumulator low part |
| ctr_addr | output | 4x6 | Read-address counters of banks 0..3 |
| ctr_inc | output | 4 | Per-bank increment strobe |

## Verification
`ctr_inc` depends on the presented instruction without any register in the path. The bench therefore samples it in the low phase of the same cycle in which the instruction is driven. RY, the two accumulator parts and the counters each pass through exactly one register, so they are sampled one time unit after the following rising edge and compared with a model updated for that single edge. The bench's RAM model returns data as a function of bank and current counter address, so a wrong bank, a wrong address or a stale counter shows up in the loaded value one edge later.

// File: rtl/ybus_pkg.sv
// Shared types for the Y-bus accumulator load unit.
// Assumes a 32-bit instruction with the Y-bus field at bits 19:17.
package ybus_pkg;

    localparam int NBANK    = 4;
    localparam int BANK_W   = 2;
    localparam int OP_LSB   = 17;
    localparam int INC_BIT  = 16;
    localparam int BANK_LSB = 14;
    localparam int CLS_LSB  = 30;

    typedef enum logic [2:0] {
        YB_NOP     = 3'b000,
        YB_CLR     = 3'b001,
        YB_ALU     = 3'b010,
        YB_RAM_ACC = 3'b011,
        YB_RAM_RY  = 3'b100
    } ybus_op_e;

    typedef struct packed {
        ybus_op_e          op;
        logic [BANK_W-1:0] bank;
        logic              post_inc;
    } ybus_ctl_t;

endpackage

// File: rtl/ybus_decode.sv
// Decodes the Y-bus field of an instruction into a control word.
// Every code outside the five defined ones is reported as YB_NOP.
// An invalid instruction, or one whose class bits are not 00, is also
// reported as YB_NOP. Purely combinational.
module ybus_decode
    import ybus_pkg::*;
(
    input  logic        vld,
    input  logic [31:0] instr,
    output ybus_ctl_t   ctl
);

    logic       active;
    logic [2:0] field;

    // Qualify the field by valid and the class bits.
    always_comb begin
        active = vld && (instr[CLS_LSB +: 2] == 2'b00);
        field  = instr[OP_LSB +: 3];
    end

    // Map the field to an operation and pass bank / post-increment through.
    always_comb begin
        ctl.bank     = instr[BANK_LSB +: BANK_W];
        ctl.post_inc = instr[INC_BIT];
        ctl.op       = YB_NOP;
        if (active) begin
            case (field)
                3'b001:  ctl.op = YB_CLR;
                3'b010:  ctl.op = YB_ALU;
                3'b011:  ctl.op = YB_RAM_ACC;
                3'b100:  ctl.op = YB_RAM_RY;
                default: ctl.op = YB_NOP;
            endcase
        end
    end

endmodule

// File: rtl/ybus_ctr_bank.sv
// Per-bank read-address counters with post-increment strobes.
// A counter steps only on a RAM-source operation with post-increment
// that selects its bank. It wraps modulo 2**ADDR_W.
module ybus_ctr_bank
    import ybus_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  ybus_ctl_t                    ctl,
    output logic [NBANK-1:0][ADDR_W-1:0] ctr_addr,
    output logic [NBANK-1:0]             ctr_inc
);

    logic ram_op;

    // Identify operations that read a RAM bank.
    always_comb begin
        ram_op = (ctl.op == YB_RAM_ACC) || (ctl.op == YB_RAM_RY);
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Strobe for this bank when it is selected with post-increment.
        always_comb begin
            ctr_inc[b] = ram_op && ctl.post_inc && (ctl.bank == BANK_W'(b));
        end

        // Address counter register for this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ctr_addr[b] <= '0;
            end else if (ctr_inc[b]) begin
                ctr_addr[b] <= ctr_addr[b] + 1'b1;
            end
        end

        // R7 / R8: a strobe advances the counter by one, modulo its width.
        p_ctr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
            ctr_inc[b] |=> ctr_addr[b] == ADDR_W'($past(ctr_addr[b]) + 1'b1));

        // R7: without a strobe the counter holds.
        p_ctr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !ctr_inc[b] |=> $stable(ctr_addr[b]));
    end

    // R7: at most one bank steps per instruction.
    p_inc_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ctr_inc));

    // R2: non-RAM operations never raise a strobe.
    p_inc_only_ram_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.op == YB_NOP || ctl.op == YB_CLR || ctl.op == YB_ALU) |-> ctr_inc == '0);

endmodule

// File: rtl/ybus_dest_regs.sv
// Destination registers: operand register RY and the split accumulator.
// RAM loads take the word of the selected bank as presented this cycle.
// All updates happen on one rising edge.
module ybus_dest_regs
    import ybus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HI_W   = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  ybus_ctl_t                    ctl,
    input  logic [NBANK-1:0][DATA_W-1:0] ram_rdata,
    input  logic [HI_W+DATA_W-1:0]       alu_res,
    output logic [DATA_W-1:0]            ry_q,
    output logic [HI_W-1:0]              acc_hi,
    output logic [DATA_W-1:0]            acc_lo
);

    localparam int ACC_W = HI_W + DATA_W;

    logic [DATA_W-1:0] bank_word;
    logic [ACC_W-1:0]  word_sext;

    // Select the addressed bank and sign-extend it to accumulator width.
    always_comb begin
        bank_word = ram_rdata[ctl.bank];
        word_sext = {{HI_W{bank_word[DATA_W-1]}}, bank_word};
    end

    // Operand register RY: loaded only by the RAM-to-RY operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ry_q <= '0;
        end else if (ctl.op == YB_RAM_RY) begin
            ry_q <= bank_word;
        end
    end

    // Accumulator: cleared, loaded from the ALU, or loaded from RAM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hi <= '0;
            acc_lo <= '0;
        end else begin
            case (ctl.op)
                YB_CLR: begin
                    acc_hi <= '0;
                    acc_lo <= '0;
                end
                YB_ALU: begin
                    acc_hi <= alu_res[ACC_W-1:DATA_W];
                    acc_lo <= alu_res[DATA_W-1:0];
                end
                YB_RAM_ACC: begin
                    acc_hi <= word_sext[ACC_W-1:DATA_W];
                    acc_lo <= word_sext[DATA_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // R3: a clear leaves both parts at zero.
    p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.op == YB_CLR |=> (acc_hi == '0) && (acc_lo == '0));

    // R4: an ALU load copies the full result.
    p_alu_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.op == YB_ALU |=> {acc_hi, acc_lo} == $past(alu_res));

    // R5: after a RAM load the high part mirrors the low part's sign.
    p_sext_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.op == YB_RAM_ACC |=> acc_hi == {HI_W{acc_lo[DATA_W-1]}});

    // R6: a RAM-to-RY load keeps the accumulator.
    p_ry_keeps_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.op == YB_RAM_RY |=> $stable(acc_hi) && $stable(acc_lo));

    // R2: a no-operation keeps every destination register.
    p_nop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.op == YB_NOP |=> $stable(ry_q) && $stable(acc_hi) && $stable(acc_lo));

    // R9: reset clears the destinations.
    p_reset_clear_r9: assert property (@(posedge clk)
        !rst_n |=> (ry_q == '0) && (acc_hi == '0) && (acc_lo == '0));

endmodule

// File: rtl/ybus_acc_load.sv
// Top of the Y-bus accumulator load unit. It decodes the Y-bus field,
// steps the per-bank address counters and updates RY and the accumulator.
// Assumes RAM read data for each bank is valid at that bank's counter
// address in the cycle the instruction is presented.
module ybus_acc_load
    import ybus_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HI_W   = 16,
    parameter int ADDR_W = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         instr_vld,
    input  logic [31:0]                  instr,
    input  logic [NBANK-1:0][DATA_W-1:0] ram_rdata,
    input  logic [HI_W+DATA_W-1:0]       alu_res,
    output logic [DATA_W-1:0]            ry_q,
    output logic [HI_W-1:0]              acc_hi,
    output logic [DATA_W-1:0]            acc_lo,
    output logic [NBANK-1:0][ADDR_W-1:0] ctr_addr,
    output logic [NBANK-1:0]             ctr_inc
);

    ybus_ctl_t ctl;

    ybus_decode u_decode (
        .vld   (instr_vld),
        .instr (instr),
        .ctl   (ctl)
    );

    ybus_ctr_bank #(
        .ADDR_W (ADDR_W)
    ) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctl      (ctl),
        .ctr_addr (ctr_addr),
        .ctr_inc  (ctr_inc)
    );

    ybus_dest_regs #(
        .DATA_W (DATA_W),
        .HI_W   (HI_W)
    ) u_dest (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .ram_rdata (ram_rdata),
        .alu_res   (alu_res),
        .ry_q      (ry_q),
        .acc_hi    (acc_hi),
        .acc_lo    (acc_lo)
    );

    // R1: an unqualified instruction raises no strobe.
    p_gate_nostrobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_vld || instr[31:30] != 2'b00) |-> ctr_inc == '0);

    // R1: an unqualified instruction changes no register.
    p_gate_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_vld || instr[31:30] != 2'b00) |=>
            $stable(ry_q) && $stable(acc_hi) && $stable(acc_lo) && $stable(ctr_addr));

endmodule

// File: tb/ybus_acc_load_tb.sv
module ybus_acc_load_tb;

    localparam int NB = 4;
    localparam int AW = 6;

    typedef struct packed {
        logic        vld;
        logic [31:0] ins;
        logic [47:0] alu;
    } vec_t;

    function automatic logic [31:0] mk(input logic [1:0] cls, input logic [2:0] op,
                                       input logic inc, input logic [1:0] bank);
        return {cls, 10'd0, op, inc, bank, 14'd0};
    endfunction

    function automatic logic [31:0] mem(input int b, input logic [AW-1:0] a);
        logic [15:0] top;
        top = ((b + int'(a)) % 2 == 1) ? 16'hC3A5 : 16'h3C5A;
        return {top, 8'(b), 2'b00, a};
    endfunction

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, mk(2'b00, 3'b010, 1'b0, 2'd0), 48'h1234_89AB_CDEF},
        '{1'b1, mk(2'b00, 3'b000, 1'b1, 2'd1), 48'h5555_5555_5555},
        '{1'b1, mk(2'b00, 3'b001, 1'b0, 2'd0), 48'h0},
        '{1'b1, mk(2'b00, 3'b011, 1'b1, 2'd0), 48'h0},
        '{1'b1, mk(2'b00, 3'b011, 1'b0, 2'd1), 48'h0},
        '{1'b1, mk(2'b00, 3'b100, 1'b1, 2'd2), 48'h0},
        '{1'b1, mk(2'b00, 3'b100, 1'b1, 2'd3), 48'h0},
        '{1'b1, mk(2'b00, 3'b011, 1'b1, 2'd0), 48'h0},
        '{1'b1, mk(2'b00, 3'b101, 1'b1, 2'd1), 48'hAAAA_0000_1111},
        '{1'b1, mk(2'b00, 3'b110, 1'b1, 2'd2), 48'hAAAA_0000_2222},
        '{1'b1, mk(2'b00, 3'b111, 1'b1, 2'd3), 48'hAAAA_0000_3333},
        '{1'b1, mk(2'b01, 3'b010, 1'b0, 2'd0), 48'h7777_7777_7777},
        '{1'b1, mk(2'b10, 3'b100, 1'b1, 2'd1), 48'h0},
        '{1'b0, mk(2'b00, 3'b001, 1'b0, 2'd0), 48'h0},
        '{1'b1, mk(2'b00, 3'b010, 1'b0, 2'd0), 48'hFFFF_0000_0001},
        '{1'b1, mk(2'b00, 3'b011, 1'b0, 2'd3), 48'h0}
    };

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    instr_vld = 1'b0;
    logic [31:0]             instr = '0;
    logic [NB-1:0][31:0]     ram_rdata;
    logic [47:0]             alu_res = '0;
    logic [31:0]             ry_q;
    logic [15:0]             acc_hi;
    logic [31:0]             acc_lo;
    logic [NB-1:0][AW-1:0]   ctr_addr;
    logic [NB-1:0]           ctr_inc;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0]           m_ry = '0;
    logic [47:0]           m_acc = '0;
    logic [NB-1:0][AW-1:0] m_ct = '0;

    always #10 clk = ~clk;

    // RAM models: each bank returns a word derived from its bank and address.
    always_comb begin
        for (int b = 0; b < NB; b++) ram_rdata[b] = mem(b, ctr_addr[b]);
    end

    ybus_acc_load u_dut (
        .clk(clk), .rst_n(rst_n), .instr_vld(instr_vld), .instr(instr),
        .ram_rdata(ram_rdata), .alu_res(alu_res), .ry_q(ry_q),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .ctr_addr(ctr_addr), .ctr_inc(ctr_inc)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic v, input logic [31:0] ins);
        if (!v || ins[31:30] != 2'b00) return "R1";
        case (ins[19:17])
            3'b001:  return "R3";
            3'b010:  return "R4";
            3'b011:  return "R5";
            3'b100:  return "R6";
            default: return "R2";
        endcase
    endfunction

    // One instruction: strobe checked in the same cycle, registers after the edge.
    task automatic step(input logic v, input logic [31:0] ins, input logic [47:0] alu);
        logic          act;
        logic [2:0]    op;
        int            bk;
        logic [NB-1:0] exp_inc;
        logic [31:0]   w;
        string         tg;
        @(negedge clk);
        instr_vld = v;
        instr     = ins;
        alu_res   = alu;
        #5;
        tg  = tag_of(v, ins);
        act = v && ins[31:30] == 2'b00;
        op  = ins[19:17];
        bk  = int'(ins[15:14]);
        w   = mem(bk, m_ct[bk]);
        exp_inc = '0;
        if (act && (op == 3'b011 || op == 3'b100) && ins[16]) exp_inc[bk] = 1'b1;
        check(ctr_inc == exp_inc, {tg, " R7 strobe"}, 64'(ctr_inc), 64'(exp_inc));
        if (act) begin
            case (op)
                3'b001: m_acc = '0;
                3'b010: m_acc = alu;
                3'b011: m_acc = {{16{w[31]}}, w};
                3'b100: m_ry  = w;
                default: ;
            endcase
        end
        if (exp_inc != '0) m_ct[bk] = m_ct[bk] + 1'b1;
        @(posedge clk);
        #1;
        check(ry_q == m_ry, {tg, " R10 ry"}, 64'(ry_q), 64'(m_ry));
        check({acc_hi, acc_lo} == m_acc, {tg, " R10 acc"}, 64'({acc_hi, acc_lo}), 64'(m_acc));
        check(ctr_addr == m_ct, {tg, " R7 ctr"}, 64'(ctr_addr), 64'(m_ct));
    endtask

    task automatic check_zero(input string tg);
        check(ry_q == '0, {tg, " ry"}, 64'(ry_q), 64'd0);
        check({acc_hi, acc_lo} == '0, {tg, " acc"}, 64'({acc_hi, acc_lo}), 64'd0);
        check(ctr_addr == '0, {tg, " ctr"}, 64'(ctr_addr), 64'd0);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check_zero("R9 reset");
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) step(VEC[i].vld, VEC[i].ins, VEC[i].alu);

        // R8: drive bank 2 to 63 and across the wrap.
        while (m_ct[2] != 6'd63) step(1'b1, mk(2'b00, 3'b100, 1'b1, 2'd2), 48'h0);
        check(ctr_addr[2] == 6'd63, "R8 at top", 64'(ctr_addr[2]), 64'd63);
        step(1'b1, mk(2'b00, 3'b011, 1'b1, 2'd2), 48'h0);
        check(ctr_addr[2] == 6'd0, "R8 wrap", 64'(ctr_addr[2]), 64'd0);

        // R5: load from the wrapped address 0 of bank 2.
        step(1'b1, mk(2'b00, 3'b011, 1'b0, 2'd2), 48'h0);
        check(acc_lo == mem(2, 6'd0), "R5 bank2 addr0", 64'(acc_lo), 64'(mem(2, 6'd0)));

        // R9: synchronous reset in mid-run, with an instruction present.
        step(1'b1, mk(2'b00, 3'b010, 1'b0, 2'd0), 48'h8001_0203_0405);
        @(negedge clk);
        rst_n = 1'b0;
        instr_vld = 1'b1;
        instr = mk(2'b00, 3'b011, 1'b1, 2'd1);
        @(posedge clk);
        #1;
        check_zero("R9 mid-run");
        @(negedge clk);
        rst_n = 1'b1;
        instr_vld = 1'b0;
        m_ry = '0;
        m_acc = '0;
        m_ct = '0;
        step(1'b1, mk(2'b00, 3'b100, 1'b1, 2'd1), 48'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule